// File: doc/BRIEF.md
# Block-Lock Status and Write-Cycle Unit

This unit sits beside the serial command decoder of a small serial nonvolatile memory. It holds the 3-bit block-lock code, turns that code into a protected address window, and tells the front end whether a given byte address may be programmed. Reading is never blocked. The protection result only gates programming.

The unit also times the self-timed nonvolatile write that follows a sector program or a status program. It also produces the bit stream the front end shifts out for the read-status command. The front end qualifies every strobe before it reaches the unit: it checks the program-enable latch, it checks that chip select rose at the right bit count, and it decodes the opcodes. A status program has two parts. First the front end presents each received protection byte with `st_load`. Then it issues `wr_start` with `wr_is_status` set when chip select rises. The new code is adopted only when the write cycle ends.

All interfaces are plain single-cycle strobes. No data stream with back-pressure crosses this boundary, so there is no valid/ready handshake. A strobe that arrives while the unit is busy is dropped.

Top module: `blk_lock_unit`

## Requirements
- R1: The status byte reads back as {5'b00000, code}. Bits 7:3 are always 0 and bits 2:0 hold the stored code. `st_data[2:0]` supplies the code.
- R2: `prot_hit` is high exactly when `chk_addr` falls in the window for the stored code. Code 0 protects nothing. Code 1 protects 0x000-0x07F. Code 2 protects 0x080-0x0FF. Code 3 protects 0x100-0x17F. Code 4 protects 0x180-0x1FF. Code 5 protects 0x000-0x0FF. Code 6 protects 0x000-0x00F. Code 7 protects 0x1F0-0x1FF.
- R3: When `st_load` pulses several times before a write starts, the last value presented is the one that gets committed.
- R4: A `wr_start` pulse sampled while idle raises `busy` from the next cycle. `busy` then stays high for exactly WR_CYCLES clocks.
- R5: While `busy` is high, both `wr_start` and `st_load` are ignored. The busy period is not lengthened and the pending code is not changed.
- R6: The stored code changes only on the clock where `busy` falls, and only if the cycle was started with `wr_is_status` = 1. A sector-program cycle (`wr_is_status` = 0) leaves the code unchanged.
- R7: `rs_begin` points the status pointer at bit 7. Each `bit_tick` moves it to the next lower bit. After bit 0 the pointer wraps to bit 7. `st_bit` shows the selected bit.
- R8: While `busy` is high, `st_bit` is 1. `bit_tick` still advances the pointer, so the bit shown after `busy` falls is the one the pointer reached.
- R9: After reset, `busy` is 0, the code equals the RST_LOCK parameter, and the pointer selects bit 7.
- R10: `prot_hit` depends combinationally on `chk_addr` and the stored code, so it is valid in the same cycle the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rs_begin | input | 1 | Start of read-status: point at bit 7 |
| bit_tick | input | 1 | Advance status pointer by one bit |
| st_load | input | 1 | Capture a received protection code |
| st_data | input | 3 | Protection code field of the received byte |
| wr_start | input | 1 | Begin a self-timed nonvolatile write |
| wr_is_status | input | 1 | With wr_start: the write targets the status register |
| chk_addr | input | ADDR_W | Byte address to test for protection |
| busy | output | 1 | Nonvolatile write cycle in progress |
| st_bit | output | 1 | Current read-status output bit |
| prot_hit | output | 1 | chk_addr lies inside the protected window |

## Verification
Two functions can meet on the same clock. The first is the end of a status write, where `busy` falls and the new code is committed. The second is a read-status stream whose pointer keeps moving while the output is forced high. The bench opens a read-status during the busy period and ticks the pointer a known number of times. It then waits for `busy` to drop and checks the bit that appears. That bit must come from the newly committed code, at the position the ticks reached. A further status write is attempted, and a new code is loaded, inside the busy window. The bench judges both by the unchanged busy length and by the code read back afterwards.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  typedef enum logic [2:0] {
    LK_NONE      = 3'd0,
    LK_QUAD0     = 3'd1,
    LK_QUAD1     = 3'd2,
    LK_QUAD2     = 3'd3,
    LK_QUAD3     = 3'd4,
    LK_LOWHALF   = 3'd5,
    LK_FIRSTSECT = 3'd6,
    LK_LASTSECT  = 3'd7
  } lock_code_e;

  localparam int unsigned STAT_W = 8;
  localparam int unsigned CODE_W = 3;
endpackage

// File: rtl/bl_range_dec.sv
module bl_range_dec
  import blk_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned SECT_W = 4
) (
  input  lock_code_e        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned QUAD = 2 ** (ADDR_W - 2);
  localparam int unsigned HALF = 2 ** (ADDR_W - 1);
  localparam int unsigned SECT = 2 ** SECT_W;
  localparam int unsigned TOP  = 2 ** ADDR_W - 1;

  logic [ADDR_W-1:0] lo, hi;
  logic              en;

  always_comb begin
    en = 1'b1;
    lo = '0;
    hi = '0;
    unique case (code)
      LK_NONE:      en = 1'b0;
      LK_QUAD0:     begin lo = ADDR_W'(0);        hi = ADDR_W'(QUAD - 1);     end
      LK_QUAD1:     begin lo = ADDR_W'(QUAD);     hi = ADDR_W'(2 * QUAD - 1); end
      LK_QUAD2:     begin lo = ADDR_W'(2 * QUAD); hi = ADDR_W'(3 * QUAD - 1); end
      LK_QUAD3:     begin lo = ADDR_W'(3 * QUAD); hi = ADDR_W'(TOP);          end
      LK_LOWHALF:   begin lo = ADDR_W'(0);        hi = ADDR_W'(HALF - 1);     end
      LK_FIRSTSECT: begin lo = ADDR_W'(0);        hi = ADDR_W'(SECT - 1);     end
      LK_LASTSECT:  begin lo = ADDR_W'(TOP - SECT + 1); hi = ADDR_W'(TOP);    end
      default:      en = 1'b0;
    endcase
    hit = en && (addr >= lo) && (addr <= hi);
  end
endmodule

// File: rtl/bl_wr_timer.sv
module bl_wr_timer #(
  parameter int unsigned CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= CNT_W'(CYC - 1);
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/bl_stat_ser.sv
module bl_stat_ser #(
  parameter int unsigned WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     restart,
  input  logic                     tick,
  output logic [$clog2(WIDTH)-1:0] ptr
);
  localparam int unsigned PTR_W = $clog2(WIDTH);
  localparam logic [PTR_W-1:0] MSB = PTR_W'(WIDTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= MSB;
    else if (restart) ptr <= MSB;
    else if (tick)    ptr <= (ptr == '0) ? MSB : ptr - 1'b1;
  end
endmodule

// File: rtl/blk_lock_unit.sv
module blk_lock_unit
  import blk_lock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned SECT_W    = 4,
  parameter int unsigned WR_CYCLES = 500000,
  parameter logic [2:0]  RST_LOCK  = 3'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rs_begin,
  input  logic              bit_tick,
  input  logic              st_load,
  input  logic [2:0]        st_data,
  input  logic              wr_start,
  input  logic              wr_is_status,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              busy,
  output logic              st_bit,
  output logic              prot_hit
);
  localparam int unsigned PTR_W = $clog2(STAT_W);

  logic [CODE_W-1:0] lock_q, pend_q;
  logic              commit_q, done, accept;
  logic [PTR_W-1:0]  ptr_q;
  logic [STAT_W-1:0] stat_byte;

  assign accept = wr_start && !busy;

  bl_wr_timer #(.CYC(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .done(done)
  );

  bl_stat_ser #(.WIDTH(STAT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .restart(rs_begin), .tick(bit_tick), .ptr(ptr_q)
  );

  bl_range_dec #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dec (
    .code(lock_code_e'(lock_q)), .addr(chk_addr), .hit(prot_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= RST_LOCK;
      pend_q   <= RST_LOCK;
      commit_q <= 1'b0;
    end else begin
      if (st_load && !busy) pend_q <= st_data;
      if (accept) commit_q <= wr_is_status;
      if (done && commit_q) lock_q <= pend_q;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < STAT_W; gi++) begin : g_stat
      if (gi < CODE_W) begin : g_code
        assign stat_byte[gi] = lock_q[gi];
      end else begin : g_rsv
        assign stat_byte[gi] = 1'b0;
      end
    end
  endgenerate

  assign st_bit = busy | stat_byte[ptr_q];
endmodule

// File: rtl/bl_lock_chk.sv
module bl_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wr_start,
  input logic       rs_begin,
  input logic       bit_tick,
  input logic       st_bit,
  input logic       prot_hit,
  input logic [2:0] lock_q,
  input logic [2:0] ptr_q
);
  AST_BUSY_FORCES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> st_bit); // R8

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_start) |=> busy); // R4

  AST_LOCK_MOVES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_q) |-> $fell(busy)); // R6

  AST_NONE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q == 3'd0) |-> !prot_hit); // R2

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ptr_q >= 3'd3) |-> !st_bit); // R1

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !rs_begin && ptr_q == 3'd0) |=> (ptr_q == 3'd7)); // R7

  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rs_begin |=> (ptr_q == 3'd7)); // R7
endmodule

bind blk_lock_unit bl_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_start(wr_start),
  .rs_begin(rs_begin), .bit_tick(bit_tick), .st_bit(st_bit),
  .prot_hit(prot_hit), .lock_q(lock_q), .ptr_q(ptr_q)
);

// File: tb/blk_lock_unit_test.sv
`timescale 1ns/100ps
module blk_lock_unit_test;
  localparam int WR  = 12;
  localparam int AW  = 9;
  localparam logic [2:0] RSTV = 3'd5;

  logic clk = 0, rst_n = 0;
  logic rs_begin = 0, bit_tick = 0, st_load = 0, wr_start = 0, wr_is_status = 0;
  logic [2:0] st_data = 0;
  logic [AW-1:0] chk_addr = 0;
  logic busy, st_bit, prot_hit;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  blk_lock_unit #(.ADDR_W(AW), .SECT_W(4), .WR_CYCLES(WR), .RST_LOCK(RSTV)) uut (
    .clk(clk), .rst_n(rst_n), .rs_begin(rs_begin), .bit_tick(bit_tick),
    .st_load(st_load), .st_data(st_data), .wr_start(wr_start),
    .wr_is_status(wr_is_status), .chk_addr(chk_addr),
    .busy(busy), .st_bit(st_bit), .prot_hit(prot_hit));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input int code, input int a);
    case (code)
      1: return a < 128;
      2: return a >= 128 && a < 256;
      3: return a >= 256 && a < 384;
      4: return a >= 384;
      5: return a < 256;
      6: return a < 16;
      7: return a >= 496;
      default: return 0;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic begin_rs();
    rs_begin = 1; step(); rs_begin = 0;
  endtask

  task automatic shift_bits(input int n, output logic [7:0] got);
    got = 0;
    for (int i = 0; i < n; i++) begin
      got = {got[6:0], st_bit};
      bit_tick = 1; step(); bit_tick = 0;
    end
  endtask

  task automatic read_status(output logic [7:0] v);
    begin_rs();
    shift_bits(8, v);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; step(); end
  endtask

  task automatic start_write(input bit is_stat);
    wr_start = 1; wr_is_status = is_stat; step(); wr_start = 0; wr_is_status = 0;
  endtask

  task automatic load(input logic [2:0] c);
    st_load = 1; st_data = c; step(); st_load = 0;
  endtask

  task automatic sweep(input int code);
    for (int a = 0; a < 512; a++) begin
      chk_addr = AW'(a); #0.1;
      chk(prot_hit == exp_hit(code, a), "R2/R10", prot_hit, exp_hit(code, a));
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  initial begin
    logic [7:0] v, w;
    int n;
    step(); step(); rst_n = 1; step();
    // R9 reset state
    chk(busy == 0, "R9 busy", busy, 0);
    read_status(v);
    chk(v == {5'b0, RSTV}, "R9/R1 status", v, RSTV);
    sweep(RSTV);

    // R1 R2 R4 R6: every code committed and decoded
    for (int c = 0; c < 8; c++) begin
      load(3'(c));
      start_write(1);
      chk(busy == 1, "R4 busy rise", busy, 1);
      wait_idle(n);
      chk(n == WR, "R4 busy length", n, WR);
      read_status(v);
      chk(v == 8'(c), "R1/R6 status", v, c);
      sweep(c);
    end

    // R3 overwrite: last of several loads wins
    load(3'd2); load(3'd6); load(3'd1);
    start_write(1); wait_idle(n);
    read_status(v);
    chk(v == 8'd1, "R3 last load", v, 1);

    // R6 sector write leaves code
    load(3'd4);
    start_write(0); wait_idle(n);
    chk(n == WR, "R4 sector length", n, WR);
    read_status(v);
    chk(v == 8'd1, "R6 sector keeps code", v, 1);

    // R5 strobes while busy ignored
    load(3'd3);
    start_write(1);
    st_load = 1; st_data = 3'd6; wr_start = 1; wr_is_status = 1; step();
    st_load = 0; wr_start = 0; wr_is_status = 0;
    wait_idle(n);
    chk(n == WR - 1, "R5 busy not extended", n + 1, WR);
    step();
    chk(busy == 0, "R5 no restart", busy, 0);
    read_status(v);
    chk(v == 8'd3, "R5 load ignored", v, 3);

    // R8 with R6/R7: pointer advances under busy, new code visible at end
    load(3'd7);
    start_write(1);
    begin_rs();
    shift_bits(5, w);
    chk(w[4:0] == 5'h1f, "R8 forced high", w[4:0], 31);
    wait_idle(n);
    chk(st_bit == 1'b1, "R8 bit2 after busy", st_bit, 1);
    shift_bits(3, w);
    chk(w[2:0] == 3'b111, "R7 bits 2..0", w[2:0], 7);
    chk(st_bit == 1'b0, "R7 wrap to bit7", st_bit, 0);
    shift_bits(8, w);
    chk(w == 8'd7, "R7 second pass", w, 7);

    // R10 combinational response
    chk_addr = 9'h1F0; #0.1;
    chk(prot_hit == 1, "R10 same cycle", prot_hit, 1);
    chk_addr = 9'h1EF; #0.1;
    chk(prot_hit == 0, "R10 edge below", prot_hit, 0);

    report();
  end
endmodule